// File: doc/BRIEF.md
# Byte-Lane Static RAM Core

This block is a synthesizable word-wide memory that reproduces the control decode of a common-I/O static RAM. It takes an address and five active-low controls: chip select, write enable, output enable, and one enable for each byte lane. From these it picks one of four modes. Writes are stored on the rising edge of the system clock. Reads come back one clock later on a separate data-out bus. Each lane has a drive flag that takes the place of a tri-state pin.

The depth is 2^ADDR_W words. The default is kept small for elaboration, and ADDR_W = 16 gives the full 65,536-word array. Each byte lane has its own storage column, so a write with one lane enabled leaves the other lane's contents unchanged. Read data and drive flags are registered per lane. A lane that is not driving shows zero on its part of the data-out bus.

The mode output is decoded combinationally from the current controls. It is meant for counting supply-current states outside the block.

Top module: `sram_byte_core`

## Requirements
- R1: The array holds 2^ADDR_W words of 16 bits, and every address from 0 to 2^ADDR_W-1 stores and returns its own value.
- R2: When cs_n is 1, mode is 0 (deselected) whatever the other controls are.
- R3: With cs_n at 0, mode is 1 (output-disable) when both lb_n and ub_n are 1, or when we_n and oe_n are both 1.
- R4: With cs_n=0, we_n=1, oe_n=0 and at least one byte enable at 0, mode is 2 (read). In the next cycle each enabled lane shows the word stored at the address sampled in the read cycle and raises its drive flag.
- R5: With cs_n=0, we_n=0 and at least one byte enable at 0, mode is 3 (write) whatever oe_n is. The enabled lanes of din are stored at the clock edge.
- R6: During a write, a lane whose enable is 1 keeps its previous contents.
- R7: lb_n governs data bits 7:0 and drive[0]. ub_n governs bits 15:8 and drive[1].
- R8: A drive flag is 1 only in the cycle after a read cycle that enabled that lane. After write, output-disable or deselected cycles both flags are 0, even when oe_n was 0. A lane whose flag is 0 shows zero on dout.
- R9: A cycle with cs_n=1 stores nothing, even with we_n and the byte enables at 0.
- R10: While rst_n is 0 and in the first cycle after it, dout and drive are 0. Reset does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower-lane enable (bits 7:0), active low |
| ub_n | input | 1 | Upper-lane enable (bits 15:8), active low |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data, zero on non-driving lanes |
| drive | output | 2 | Registered per-lane drive flags, bit 0 lower lane |
| mode | output | 2 | Current mode: 0 deselected, 1 output-disable, 2 read, 3 write |

## Verification
The assertions assume the controls are settled before each rising edge and hold for a full cycle, so that each cycle is exactly one mode. They also assume that read results are judged one cycle after the read cycle. The bench changes every input half a period away from the edge and keeps it steady until the next change. Before any read it writes the address it will read, so no result depends on uninitialised array contents. It steps through every mode, including write cycles with oe_n at 0 and deselected cycles with the write controls active.

// File: rtl/sram_byte_pkg.sv
// Package: shared types for the byte-lane static RAM core.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sram_byte_pkg;
    typedef enum logic [1:0] {
        MODE_DESEL   = 2'd0,
        MODE_OUT_OFF = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } sram_mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
// Module: decodes the five active-low controls into a mode and per-lane
// read/write strobes. Purely combinational; assumes the lane enables arrive
// as a vector with bit 0 for the lower lane.
module sram_mode_decode
    import sram_byte_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] ben_n,
    output sram_mode_e       mode,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_rd
);
    logic no_lane;

    // Flag the case where no byte lane is enabled.
    always_comb no_lane = &ben_n;

    // Pick the mode; a write dominates the output enable.
    always_comb begin
        if (cs_n)
            mode = MODE_DESEL;
        else if (no_lane)
            mode = MODE_OUT_OFF;
        else if (!we_n)
            mode = MODE_WRITE;
        else if (!oe_n)
            mode = MODE_READ;
        else
            mode = MODE_OUT_OFF;
    end

    // Qualify each lane strobe with its own enable.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_wr[i] = (mode == MODE_WRITE) && !ben_n[i];
            lane_rd[i] = (mode == MODE_READ)  && !ben_n[i];
        end
    end
endmodule

// File: rtl/sram_lane_store.sv
// Module: one byte lane of storage with a registered read port and drive
// flag. Assumes at most one of wr_en/rd_en is set per cycle. The array
// itself is not reset; the read register and drive flag are.
module sram_lane_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata,
    output logic              drive
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    // Store the lane on a write edge.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[addr] <= wdata;
    end

    // Register read data and its drive flag; idle lanes read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            drive <= 1'b0;
        end else begin
            rdata <= rd_en ? mem[addr] : '0;
            drive <= rd_en;
        end
    end
endmodule

// File: rtl/sram_byte_core.sv
// Module: top of the byte-lane static RAM core. Splits the word into byte
// lanes, decodes the mode once and gives each lane its own storage column.
// Assumes inputs are stable around each rising clock edge.
module sram_byte_core
    import sram_byte_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                lb_n,
    input  logic                ub_n,
    input  logic [2*LANE_W-1:0] din,
    output logic [2*LANE_W-1:0] dout,
    output logic [1:0]          drive,
    output logic [1:0]          mode
);
    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0] ben_n;
    logic [LANES-1:0] lane_wr;
    logic [LANES-1:0] lane_rd;
    sram_mode_e       mode_e;

    // Gather the lane enables, lower lane in bit 0.
    always_comb ben_n = {ub_n, lb_n};

    sram_mode_decode #(.LANES(LANES)) u_decode (
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .ben_n   (ben_n),
        .mode    (mode_e),
        .lane_wr (lane_wr),
        .lane_rd (lane_rd)
    );

    // Report the decoded mode as a plain code.
    always_comb mode = mode_e;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (addr),
            .wr_en (lane_wr[g]),
            .rd_en (lane_rd[g]),
            .wdata (din[g*LANE_W +: LANE_W]),
            .rdata (dout[g*LANE_W +: LANE_W]),
            .drive (drive[g])
        );
    end

    if (DATA_W != 2 * LANE_W) begin : g_bad_width
        initial $error("lane width mismatch");
    end
endmodule

// File: rtl/sram_byte_core_chk.sv
// Module: protocol checker for sram_byte_core, attached by bind.
// Assumes one mode per clock cycle with inputs stable around the edge.
module sram_byte_core_chk #(
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                we_n,
    input logic                oe_n,
    input logic                lb_n,
    input logic                ub_n,
    input logic [2*LANE_W-1:0] dout,
    input logic [1:0]          drive,
    input logic [1:0]          mode
);
    assert_desel_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> mode == 2'd0);

    assert_no_lane_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && lb_n && ub_n) |-> mode == 2'd1);

    assert_write_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n && !(lb_n && ub_n)) |-> mode == 2'd3);

    assert_read_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !lb_n) |=> drive[0]);

    assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |=> drive == 2'b00);

    assert_upper_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive[1] |-> $past(!ub_n && !cs_n && we_n && !oe_n));

    assert_idle_lane_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive[0] |-> dout[LANE_W-1:0] == '0) and
        (!drive[1] |-> dout[2*LANE_W-1:LANE_W] == '0));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(!rst_n) |-> drive == 2'b00);
endmodule

bind sram_byte_core sram_byte_core_chk #(.LANE_W(LANE_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .we_n  (we_n),
    .oe_n  (oe_n),
    .lb_n  (lb_n),
    .ub_n  (ub_n),
    .dout  (dout),
    .drive (drive),
    .mode  (mode)
);

// File: tb/sram_byte_core_test.sv
// Scoreboard bench: step() drives one cycle, checks the mode, and queues the
// output expected one clock later; the monitor pops and compares.
module sram_byte_core_test;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct {
        logic [15:0] dout;
        logic [1:0]  drv;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0]       din = '0;
    logic [15:0]       dout;
    logic [1:0]        drive;
    logic [1:0]        mode;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] model [DEPTH];
    exp_t        q [$];

    always #10 clk = ~clk;

    sram_byte_core #(.ADDR_W(ADDR_W), .LANE_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
        .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .din(din), .dout(dout),
        .drive(drive), .mode(mode)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(logic c, logic w, logic o, logic l, logic u);
        if (c) return 2'd0;
        if (l && u) return 2'd1;
        if (!w) return 2'd3;
        if (!o) return 2'd2;
        return 2'd1;
    endfunction

    // Drive one cycle, check the mode, queue the next-cycle outputs.
    task automatic step(input logic c, w, o, l, u, input int a,
                        input logic [15:0] d, input string tag);
        exp_t        e;
        logic [1:0]  m;
        @(negedge clk);
        #1;
        cs_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u;
        addr = a[ADDR_W-1:0]; din = d;
        #1;
        m = exp_mode(c, w, o, l, u);
        check(mode == m, {tag, " mode"}, {14'd0, mode}, {14'd0, m});
        e.tag = tag; e.dout = '0; e.drv = 2'b00;
        if (m == 2'd2) begin
            if (!l) begin e.dout[7:0]  = model[a][7:0];  e.drv[0] = 1'b1; end
            if (!u) begin e.dout[15:8] = model[a][15:8]; e.drv[1] = 1'b1; end
        end
        if (m == 2'd3) begin
            if (!l) model[a][7:0]  = d[7:0];
            if (!u) model[a][15:8] = d[15:8];
        end
        q.push_back(e);
    endtask

    // Monitor: compare queued expectations one clock after their cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(dout == e.dout, {e.tag, " data"}, dout, e.dout);
            check(drive == e.drv, {e.tag, " drive"}, {14'd0, drive}, {14'd0, e.drv});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dout == 16'h0 && drive == 2'b00, "R10 in reset", dout, 16'h0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(dout == 16'h0 && drive == 2'b00, "R10 after reset", dout, 16'h0);

        // R5 full writes, oe_n low ignored; R1 lowest and highest address
        step(0, 0, 0, 0, 0, 0,         16'hA5C3, "R5 write oe low R8");
        step(0, 0, 1, 0, 0, DEPTH - 1, 16'h1234, "R1 write top");
        step(0, 1, 0, 0, 0, 0,         16'h0,    "R4 read addr0");
        step(0, 1, 0, 0, 0, DEPTH - 1, 16'h0,    "R1 read top");

        // R6 / R7 partial-lane writes
        step(0, 0, 1, 0, 0, 5, 16'hFFFF, "R5 write base");
        step(0, 0, 1, 0, 1, 5, 16'h0011, "R6 lower only");
        step(0, 0, 0, 1, 0, 5, 16'hAB22, "R6 upper only");
        step(0, 1, 0, 0, 0, 5, 16'h0,    "R6 read merged");
        step(0, 1, 0, 0, 1, 5, 16'h0,    "R7 read lower lane");
        step(0, 1, 0, 1, 0, 5, 16'h0,    "R7 read upper lane");

        // R9 deselected write, R2 mode
        step(1, 0, 0, 0, 0, 5, 16'h0000, "R9 desel write R2");
        step(0, 1, 0, 0, 0, 5, 16'h0,    "R9 read after desel");

        // R3 both lanes off during write, and output-disable
        step(0, 0, 0, 1, 1, 5, 16'h0000, "R3 no lane write");
        step(0, 1, 1, 0, 0, 5, 16'h0,    "R3 out disable R8");
        step(0, 1, 0, 1, 1, 5, 16'h0,    "R3 read no lane");
        step(0, 1, 0, 0, 0, 5, 16'h0,    "R3 read unchanged");

        // R4 back-to-back reads over a written range
        for (int i = 0; i < 16; i++)
            step(0, 0, 1, 0, 0, 100 + i * 37, 16'(i * 16'h1357 + 16'h0F0F), "R1 fill");
        for (int i = 15; i >= 0; i--)
            step(0, 1, 0, 0, 0, 100 + i * 37, 16'h0, "R4 stream read");
        step(1, 1, 1, 1, 1, 0, 16'h0, "R8 idle");

        @(negedge clk);
        #3;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule